// File: doc/BRIEF.md
# State-Save Fault Arbiter

This block decides, before any memory is touched, which fault a 512-byte processor state-save store must raise. It looks at the current operating mode, the instruction's prefix and feature status, the coprocessor control bits, the privilege level, the alignment-check enable, any pending floating-point exception, any segment-limit violation reported by the address unit, and the effective address. It returns a single fault at most, plus a flag that says whether the fault pushes an error code of zero.

A request is sampled on one clock edge. The registered verdict appears on the next edge and stays valid until the consumer acknowledges it. When several conditions hold at once, a fixed priority picks the winner. Misalignment can be reported as an alignment-check fault or as a general-protection fault. A build-time policy makes that choice, and the policy can depend on how coarse the misalignment is.

Top module: `ssave_fault_chk`

## Requirements
- R1: After reset, and whenever no result is pending, `valid_o` is 0, `fault_o` is 0 and `err_zero_o` is 0.
- R2: A request is accepted when `req_i` is high and either no result is pending or `ack_i` is high in the same cycle. The verdict is valid from the next clock edge and holds unchanged until `ack_i`. A request made while a result is pending and unacknowledged is dropped.
- R3: A set `lock_i` or a cleared `feat_i` gives the undefined-opcode fault, `fault_o` bit 0. This fault outranks every other.
- R4: A set `cr0_ts_i` or `cr0_em_i` gives the device-unavailable fault, `fault_o` bit 1. Only bit 0 outranks it.
- R5: In 64-bit mode (`mode_i`=4), a pending x87 exception gives the math fault, `fault_o` bit 2. In any other mode, a pending x87 exception has no effect.
- R6: In 64-bit mode, an address is canonical when bits 63:47 are all equal. A non-canonical address gives the stack fault (bit 4) when `seg_ss_i` is set, and the general-protection fault (bit 3) otherwise.
- R7: In real mode (0) and virtual-8086 mode (1), an operand whose last byte (address+511) lies above FFFFh gives the general-protection fault.
- R8: In protected mode (2) and compatibility mode (3), `seg_viol_i` gives bit 4 if `seg_ss_i` is set and bit 3 otherwise. In the other modes, `seg_viol_i` is ignored.
- R9: An address with any of bits 3:0 set is misaligned. Outside virtual-8086 mode, misalignment gives bit 3. Under the default odd-only policy, the fault is instead the alignment-check fault (bit 5) when the address is odd, `ac_en_i` is set, `cpl_i`=3, and the mode is not real.
- R10: In virtual-8086 mode, a misaligned address always gives bit 5.
- R11: The priority order is: undefined opcode, device unavailable, math, addressing, alignment. At most one bit of `fault_o` is set, and 0 means no fault.
- R12: `err_zero_o` is 1 exactly when the reported fault is bit 3, 4 or 5 and the mode is not real.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Evaluate the current inputs |
| ack_i | input | 1 | Consumer takes the pending verdict |
| mode_i | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| lock_i | input | 1 | Lock prefix present |
| feat_i | input | 1 | State-save feature supported |
| cr0_ts_i | input | 1 | Task-switched control bit |
| cr0_em_i | input | 1 | Emulation control bit |
| cpl_i | input | 2 | Current privilege level |
| ac_en_i | input | 1 | Alignment check enabled |
| x87_pend_i | input | 1 | Unmasked x87 exception pending |
| seg_viol_i | input | 1 | Segment limit violated |
| seg_ss_i | input | 1 | Reference uses the stack segment |
| addr_i | input | 64 | Effective/linear address |
| valid_o | output | 1 | Verdict valid |
| fault_o | output | 6 | One-hot fault: 0 UD, 1 NM, 2 MF, 3 GP, 4 SS, 5 AC |
| err_zero_o | output | 1 | Fault pushes a zero error code |

## Verification
On every cycle, the bound checker enforces the at-most-one-hot verdict, the cleared idle outputs, and the stability of a held verdict. It also checks that an accepted request is answered on the next edge and that an acknowledge without a request clears the result. It further checks that the two top-priority faults win whenever their conditions are accepted, and that the error-code flag goes only with the three addressing and alignment faults. The mode-dependent choices need the bench's directed vectors: canonical edges, the real-mode wrap at FFFFh, seg-limit handling per mode, AC-versus-GP by misalignment width and privilege, and priority collisions. The same holds for the dropped request during a hold and the back-to-back acknowledge.

// File: rtl/ssave_pkg.sv
package ssave_pkg;
  typedef enum logic [2:0] {
    MD_REAL   = 3'd0,
    MD_V86    = 3'd1,
    MD_PROT   = 3'd2,
    MD_COMPAT = 3'd3,
    MD_LONG   = 3'd4
  } cpu_mode_e;

  typedef enum logic [1:0] {
    ALN_GP_ONLY = 2'd0,
    ALN_AC_ANY  = 2'd1,
    ALN_AC_ODD  = 2'd2
  } align_pol_e;

  localparam int FLT_W  = 6;
  localparam int FB_UD  = 0;
  localparam int FB_NM  = 1;
  localparam int FB_MF  = 2;
  localparam int FB_GP  = 3;
  localparam int FB_SS  = 4;
  localparam int FB_AC  = 5;

  typedef struct packed {
    logic ud;
    logic nm;
    logic mf;
    logic addr_gp;
    logic addr_ss;
    logic aln_gp;
    logic aln_ac;
  } cand_t;
endpackage

// File: rtl/ssave_addr_judge.sv
module ssave_addr_judge
  import ssave_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CANON_MSB = 47,
  parameter int REAL_W    = 16,
  parameter int SAVE_BYTES = 512
) (
  input  cpu_mode_e          mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               seg_viol,
  input  logic               seg_ss,
  output logic               addr_gp,
  output logic               addr_ss
);
  localparam int SPAN_LAST = SAVE_BYTES - 1;

  logic [ADDR_W-1:CANON_MSB] upper;
  logic                      canon;
  logic [REAL_W:0]           last_byte;
  logic                      real_out;

  assign upper     = addr[ADDR_W-1:CANON_MSB];
  assign canon     = (&upper) | ~(|upper);
  assign last_byte = {1'b0, addr[REAL_W-1:0]} + (REAL_W+1)'(SPAN_LAST);
  assign real_out  = last_byte[REAL_W] | (|addr[ADDR_W-1:REAL_W]);

  always_comb begin
    addr_gp = 1'b0;
    addr_ss = 1'b0;
    unique case (mode)
      MD_REAL, MD_V86: addr_gp = real_out;
      MD_PROT, MD_COMPAT: begin
        addr_ss = seg_viol & seg_ss;
        addr_gp = seg_viol & ~seg_ss;
      end
      MD_LONG: begin
        addr_ss = ~canon & seg_ss;
        addr_gp = ~canon & ~seg_ss;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssave_align_judge.sv
module ssave_align_judge
  import ssave_pkg::*;
#(
  parameter int         ALIGN_BYTES  = 16,
  parameter align_pol_e ALIGN_POLICY = ALN_AC_ODD
) (
  input  cpu_mode_e                     mode,
  input  logic [$clog2(ALIGN_BYTES)-1:0] low,
  input  logic [1:0]                    cpl,
  input  logic                          ac_en,
  output logic                          aln_gp,
  output logic                          aln_ac
);
  logic mis;
  logic ac_allowed;
  logic pick_ac;

  assign mis        = |low;
  assign ac_allowed = ac_en & (cpl == 2'd3) & (mode != MD_REAL);

  generate
    if (ALIGN_POLICY == ALN_GP_ONLY) begin : g_gp
      assign pick_ac = 1'b0;
    end else if (ALIGN_POLICY == ALN_AC_ANY) begin : g_any
      assign pick_ac = ac_allowed;
    end else begin : g_odd
      assign pick_ac = ac_allowed & low[0];
    end
  endgenerate

  always_comb begin
    if (mode == MD_V86) begin
      aln_ac = mis;
      aln_gp = 1'b0;
    end else begin
      aln_ac = mis & pick_ac;
      aln_gp = mis & ~pick_ac;
    end
  end
endmodule

// File: rtl/ssave_prio.sv
module ssave_prio
  import ssave_pkg::*;
(
  input  cpu_mode_e         mode,
  input  cand_t             cand,
  output logic [FLT_W-1:0]  fault,
  output logic              err_zero
);
  always_comb begin
    fault = '0;
    if (cand.ud)           fault[FB_UD] = 1'b1;
    else if (cand.nm)      fault[FB_NM] = 1'b1;
    else if (cand.mf)      fault[FB_MF] = 1'b1;
    else if (cand.addr_ss) fault[FB_SS] = 1'b1;
    else if (cand.addr_gp) fault[FB_GP] = 1'b1;
    else if (cand.aln_ac)  fault[FB_AC] = 1'b1;
    else if (cand.aln_gp)  fault[FB_GP] = 1'b1;
    err_zero = (fault[FB_GP] | fault[FB_SS] | fault[FB_AC]) & (mode != MD_REAL);
  end
endmodule

// File: rtl/ssave_fault_chk.sv
module ssave_fault_chk
  import ssave_pkg::*;
#(
  parameter int         ADDR_W       = 64,
  parameter int         CANON_MSB    = 47,
  parameter int         REAL_W       = 16,
  parameter int         SAVE_BYTES   = 512,
  parameter int         ALIGN_BYTES  = 16,
  parameter align_pol_e ALIGN_POLICY = ALN_AC_ODD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [2:0]        mode_i,
  input  logic              lock_i,
  input  logic              feat_i,
  input  logic              cr0_ts_i,
  input  logic              cr0_em_i,
  input  logic [1:0]        cpl_i,
  input  logic              ac_en_i,
  input  logic              x87_pend_i,
  input  logic              seg_viol_i,
  input  logic              seg_ss_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [5:0]        fault_o,
  output logic              err_zero_o
);
  localparam int LOW_W = $clog2(ALIGN_BYTES);

  cpu_mode_e          mode;
  cand_t              cand;
  logic               a_gp, a_ss, l_gp, l_ac;
  logic [FLT_W-1:0]   fault_nx;
  logic               err_nx;
  logic               accept;

  assign mode = cpu_mode_e'(mode_i);

  ssave_addr_judge #(
    .ADDR_W(ADDR_W), .CANON_MSB(CANON_MSB),
    .REAL_W(REAL_W), .SAVE_BYTES(SAVE_BYTES)
  ) u_addr (
    .mode(mode), .addr(addr_i), .seg_viol(seg_viol_i),
    .seg_ss(seg_ss_i), .addr_gp(a_gp), .addr_ss(a_ss)
  );

  ssave_align_judge #(
    .ALIGN_BYTES(ALIGN_BYTES), .ALIGN_POLICY(ALIGN_POLICY)
  ) u_align (
    .mode(mode), .low(addr_i[LOW_W-1:0]), .cpl(cpl_i),
    .ac_en(ac_en_i), .aln_gp(l_gp), .aln_ac(l_ac)
  );

  always_comb begin
    cand.ud      = lock_i | ~feat_i;
    cand.nm      = cr0_ts_i | cr0_em_i;
    cand.mf      = x87_pend_i & (mode == MD_LONG);
    cand.addr_gp = a_gp;
    cand.addr_ss = a_ss;
    cand.aln_gp  = l_gp;
    cand.aln_ac  = l_ac;
  end

  ssave_prio u_prio (
    .mode(mode), .cand(cand), .fault(fault_nx), .err_zero(err_nx)
  );

  assign accept = req_i & (~valid_o | ack_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      fault_o    <= '0;
      err_zero_o <= 1'b0;
    end else if (accept) begin
      valid_o    <= 1'b1;
      fault_o    <= fault_nx;
      err_zero_o <= err_nx;
    end else if (ack_i) begin
      valid_o    <= 1'b0;
      fault_o    <= '0;
      err_zero_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ssave_fault_chk_sva.sv
module ssave_fault_chk_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_i,
  input logic       ack_i,
  input logic       lock_i,
  input logic       feat_i,
  input logic       cr0_ts_i,
  input logic       cr0_em_i,
  input logic       valid_o,
  input logic [5:0] fault_o,
  input logic       err_zero_o
);
  logic acc;
  assign acc = req_i & (~valid_o | ack_i);

  // R11
  fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_o));
  // R1
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (fault_o == 6'd0 && !err_zero_o));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ack_i |=> valid_o && $stable(fault_o) && $stable(err_zero_o));
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> valid_o);
  // R2
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o && ack_i && !req_i |=> !valid_o);
  // R3
  ud_win_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (lock_i || !feat_i) |=> fault_o[0]);
  // R4
  nm_win_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !lock_i && feat_i && (cr0_ts_i || cr0_em_i) |=> fault_o[1]);
  // R12
  err_code_chk: assert property (@(posedge clk) disable iff (rst)
    err_zero_o |-> (fault_o[3] || fault_o[4] || fault_o[5]));
endmodule

bind ssave_fault_chk ssave_fault_chk_sva u_sva (
  .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i),
  .lock_i(lock_i), .feat_i(feat_i), .cr0_ts_i(cr0_ts_i), .cr0_em_i(cr0_em_i),
  .valid_o(valid_o), .fault_o(fault_o), .err_zero_o(err_zero_o)
);

// File: tb/ssave_fault_chk_tb_top.sv
module ssave_fault_chk_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0, ack_i = 1'b0;
  logic [2:0] mode_i = 3'd2;
  logic lock_i = 1'b0, feat_i = 1'b1, cr0_ts_i = 1'b0, cr0_em_i = 1'b0;
  logic [1:0] cpl_i = 2'd0;
  logic ac_en_i = 1'b0, x87_pend_i = 1'b0, seg_viol_i = 1'b0, seg_ss_i = 1'b0;
  logic [63:0] addr_i = 64'h1000;
  logic valid_o;
  logic [5:0] fault_o;
  logic err_zero_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssave_fault_chk dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i), .mode_i(mode_i),
    .lock_i(lock_i), .feat_i(feat_i), .cr0_ts_i(cr0_ts_i), .cr0_em_i(cr0_em_i),
    .cpl_i(cpl_i), .ac_en_i(ac_en_i), .x87_pend_i(x87_pend_i),
    .seg_viol_i(seg_viol_i), .seg_ss_i(seg_ss_i), .addr_i(addr_i),
    .valid_o(valid_o), .fault_o(fault_o), .err_zero_o(err_zero_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic        lock;
    logic        feat;
    logic        ts;
    logic        em;
    logic [1:0]  cpl;
    logic        acen;
    logic        x87;
    logic        segv;
    logic        isss;
    logic [63:0] addr;
    logic [5:0]  xf;
    logic        xe;
    logic [7:0]  rid;
  } vec_t;

  localparam int NV = 26;
  // fault codes: 01 UD, 02 NM, 04 MF, 08 GP, 10 SS, 20 AC
  localparam vec_t VECS [NV] = '{
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'h1000,6'h00,1'b0,8'd11}, // R11 clean
    '{3'd2,1'b1,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'h1000,6'h01,1'b0,8'd3},  // R3 lock
    '{3'd4,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,64'h1001,6'h01,1'b0,8'd3},  // R3 no feature beats all
    '{3'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,64'h1000,6'h02,1'b0,8'd4},  // R4 ts
    '{3'd4,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,1'b1,1'b0,1'b0,64'h1000,6'h02,1'b0,8'd4},  // R4 em over mf
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,64'h1003,6'h04,1'b0,8'd5},  // R5 mf over align
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,64'h1000,6'h00,1'b0,8'd5},  // R5 ignored outside 64
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'h0000_8000_0000_0000,6'h08,1'b1,8'd6}, // R6
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,64'h0000_8000_0000_0000,6'h10,1'b1,8'd6}, // R6
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'hFFFF_8000_0000_0000,6'h00,1'b0,8'd6}, // R6
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'h0000_7FFF_FFFF_FFF0,6'h00,1'b0,8'd6}, // R6
    '{3'd0,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'hFE00,6'h00,1'b0,8'd7},  // R7 fits
    '{3'd0,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,64'hFE10,6'h08,1'b0,8'd7},  // R7 wraps
    '{3'd1,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,64'h10000,6'h08,1'b1,8'd7}, // R7 v86
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,64'h1000,6'h08,1'b1,8'd8},  // R8
    '{3'd3,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,64'h1000,6'h10,1'b1,8'd8},  // R8
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,64'h1000,6'h00,1'b0,8'd8},  // R8 ignored
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,64'h1001,6'h20,1'b1,8'd9},  // R9 odd AC
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,64'h1002,6'h08,1'b1,8'd9},  // R9 2-aligned GP
    '{3'd2,1'b0,1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,64'h1001,6'h08,1'b1,8'd9},  // R9 cpl0 GP
    '{3'd0,1'b0,1'b1,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,64'h1001,6'h08,1'b0,8'd9},  // R9 real GP
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,64'h1008,6'h08,1'b1,8'd9},  // R9 64 GP
    '{3'd1,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,64'h1004,6'h20,1'b1,8'd10}, // R10
    '{3'd1,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0,1'b0,1'b0,1'b0,64'h1010,6'h00,1'b0,8'd10}, // R10 aligned
    '{3'd4,1'b0,1'b1,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b1,64'h0000_8000_0000_0001,6'h10,1'b1,8'd11}, // R11
    '{3'd1,1'b0,1'b1,1'b0,1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,64'hFE11,6'h08,1'b1,8'd11}  // R11 addr over AC
  };

  task automatic chk(input int rid, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rid, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i = v.mode; lock_i = v.lock; feat_i = v.feat; cr0_ts_i = v.ts;
    cr0_em_i = v.em; cpl_i = v.cpl; ac_en_i = v.acen; x87_pend_i = v.x87;
    seg_viol_i = v.segv; seg_ss_i = v.isss; addr_i = v.addr;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(1, {7'd0, valid_o}, 8'd0, "valid after reset");
    chk(1, {2'd0, fault_o}, 8'd0, "fault after reset");
    chk(1, {7'd0, err_zero_o}, 8'd0, "err after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      chk(VECS[i].rid, {7'd0, valid_o}, 8'd1, "valid");
      chk(VECS[i].rid, {2'd0, fault_o}, {2'd0, VECS[i].xf}, "fault");
      chk(VECS[i].rid, {7'd0, err_zero_o}, {7'd0, VECS[i].xe}, "err_zero");
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      chk(1, {7'd0, valid_o}, 8'd0, "valid after ack");
    end

    // R2 hold while unacknowledged; new request dropped
    drive(VECS[1]);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    drive(VECS[3]);
    req_i = 1'b1;
    repeat (3) @(negedge clk);
    req_i = 1'b0;
    chk(2, {7'd0, valid_o}, 8'd1, "held valid");
    chk(2, {2'd0, fault_o}, 8'h01, "held fault");
    // R2 ack with request: back-to-back
    ack_i = 1'b1; req_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0; req_i = 1'b0;
    chk(2, {7'd0, valid_o}, 8'd1, "back-to-back valid");
    chk(2, {2'd0, fault_o}, 8'h02, "back-to-back fault");
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk(1, {2'd0, fault_o}, 8'd0, "idle fault");
    chk(1, {7'd0, err_zero_o}, 8'd0, "idle err");

    // R1 reset clears a pending verdict
    drive(VECS[7]);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(1, {7'd0, valid_o}, 8'd0, "valid after mid reset");
    chk(1, {2'd0, fault_o}, 8'd0, "fault after mid reset");

    done = 1'b1;
    finish_run();
  end
endmodule